// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits at the slave end of a two-wire serial bus. It follows the clock and data lines, which arrive already sampled into the system clock domain, and finds start, repeated-start and stop conditions on them. After every start it shifts in the first byte, most significant bit first, on rising clock edges. It then sorts that byte into one of these classes: the device's own 7-bit address, a general call, a start byte, the CBUS code, a high-speed master code, a 10-bit address prefix, or another reserved code. It pulls the data line low during the ninth clock pulse only for its own address, or for a general call when general-call acceptance is enabled. It reports the direction bit and which class was seen.

The sequencing is done by a state machine with six states. IDLE waits for a start. ADDR shifts in the first byte; when the eighth bit has arrived it moves to ACK_WAIT and registers the classification. ACK_WAIT goes on the next falling clock edge, either to ACK_DRIVE if the byte is to be acknowledged or to IGNORE if not. ACK_DRIVE pulls the data line low and goes to ACTIVE on the falling edge that ends the ninth pulse. ACTIVE keeps the flags through the data phase. IGNORE leaves the bus alone. Two transitions apply in every state. A start condition takes the machine to ADDR and clears the flags. A stop condition takes it to IDLE and clears the flags.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: A start condition (data falling while clock is high) begins reception of a new first byte, and the flags are low right after it.
- R2: Address bits are taken on rising clock edges, most significant bit first. A byte whose upper 7 bits equal own_addr_i sets addressed_o and is acknowledged.
- R3: rw_o carries bit 0 of the first byte: 0 means the master writes and 1 means the master reads.
- R4: sda_drive_low_o is low while the eighth bit's clock is high. It rises after the falling edge that follows the eighth bit. It falls after the falling edge that ends the ninth pulse.
- R5: The byte 0x00 with gc_en_i=1 is acknowledged and sets gen_call_o, while addressed_o stays low.
- R6: The byte 0x00 with gc_en_i=0 is not acknowledged and sets no flag.
- R7: The start byte 0x01 is never acknowledged and sets reserved_o.
- R8: The reserved codes 0000001x, 0000010x, 0000011x, 00001xxx, 11110xxx and 11111xxx set reserved_o and are never acknowledged, even when own_addr_i holds the same 7-bit value.
- R9: After a first byte that is not acknowledged, the block ignores the bus until the next start. A later byte equal to its own address, sent without a new start, gets no acknowledge and sets no flag.
- R10: A repeated start at any point, including in the middle of a byte or after an acknowledge, aborts the current state and restarts address reception.
- R11: A stop condition (data rising while clock is high) returns the block to IDLE with every output low. This is also the reset state.
- R12: After an acknowledge, addressed_o or gen_call_o stays set through the data bytes until the next start or stop, and data bytes are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| own_addr_i | input | 7 | The device's own 7-bit address |
| gc_en_i | input | 1 | Accept and acknowledge general calls |
| sda_drive_low_o | output | 1 | Pull the data line low (acknowledge) |
| addressed_o | output | 1 | Own address matched |
| gen_call_o | output | 1 | General call accepted |
| rw_o | output | 1 | Direction bit of the first byte |
| reserved_o | output | 1 | First byte was a reserved code |

## Verification
The bench builds the block with its default parameters: a 7-bit address and two synchronizer stages. Each half period of the bus clock lasts ten system clocks. The four-cycle lag through the synchronizer and the edge detector is therefore well inside one bus phase, so the acknowledge window can be checked at fixed points: at the end of the eighth high phase, in the middle of the ninth low phase, and after the ninth pulse ends. With these values the bench can also reach a repeated start in the middle of a byte, a stop in the middle of a byte, an own address set to a reserved value, and a matching byte sent after a mismatch without a new start.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_ACTIVE,
        ST_IGNORE
    } rcv_state_t;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_OWN,
        CLS_GCALL,
        CLS_STARTB,
        CLS_CBUS,
        CLS_HSMC,
        CLS_TENBIT,
        CLS_RSVD
    } byte_class_t;

endpackage

// File: rtl/i2c_ar_sampler.sv
module i2c_ar_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_s, sda_s;
    logic scl_d, sda_d;

    generate
        if (SYNC_STAGES == 0) begin : g_pass
            assign scl_s = scl_i;
            assign sda_s = sda_i;
        end else if (SYNC_STAGES == 1) begin : g_one
            logic scl_r, sda_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_i;
                    sda_r <= sda_i;
                end
            end
            assign scl_s = scl_r;
            assign sda_s = sda_r;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] scl_p, sda_p;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= {scl_p[SYNC_STAGES-2:0], scl_i};
                    sda_p <= {sda_p[SYNC_STAGES-2:0], sda_i};
                end
            end
            assign scl_s = scl_p[SYNC_STAGES-1];
            assign sda_s = sda_p[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_o      = scl_s;
    assign sda_o      = sda_s;
    assign scl_rise_o = ~scl_d & scl_s;
    assign scl_fall_o = scl_d & ~scl_s;
    assign start_o    = scl_d & scl_s & sda_d & ~sda_s;
    assign stop_o     = scl_d & scl_s & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_ar_shifter.sv
module i2c_ar_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              full_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_i && !full_o) begin
            sh_q  <= {sh_q[BYTE_W-2:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign byte_o = sh_q;
    assign full_o = (cnt_q == CNT_W'(BYTE_W));

endmodule

// File: rtl/i2c_ar_classify.sv
module i2c_ar_classify
    import i2c_ar_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   byte_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic              gc_en_i,
    output logic              own_hit_o,
    output logic              gc_hit_o,
    output logic              rsvd_o
);

    logic [ADDR_W-1:0] addr;
    logic              dir;
    logic [3:0]        hi;
    logic [ADDR_W-6:0] rest;
    byte_class_t       cls;

    assign addr = byte_i[ADDR_W:1];
    assign dir  = byte_i[0];
    assign hi   = addr[ADDR_W-1 -: 4];
    assign rest = addr[ADDR_W-6:0];

    always_comb begin
        cls = CLS_NONE;
        if (hi == 4'h0) begin
            if (addr[ADDR_W-5])
                cls = CLS_HSMC;
            else if (rest == '0)
                cls = dir ? CLS_STARTB : CLS_GCALL;
            else if (rest == (ADDR_W-5)'(1))
                cls = CLS_CBUS;
            else
                cls = CLS_RSVD;
        end else if (hi == 4'hF) begin
            cls = addr[ADDR_W-5] ? CLS_RSVD : CLS_TENBIT;
        end else if (addr == own_i) begin
            cls = CLS_OWN;
        end
    end

    always_comb begin
        own_hit_o = 1'b0;
        gc_hit_o  = 1'b0;
        rsvd_o    = 1'b0;
        unique case (cls)
            CLS_OWN:   own_hit_o = 1'b1;
            CLS_GCALL: gc_hit_o  = gc_en_i;
            CLS_STARTB, CLS_CBUS, CLS_HSMC, CLS_TENBIT, CLS_RSVD:
                       rsvd_o    = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
    import i2c_ar_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    output logic              sda_drive_low_o,
    output logic              addressed_o,
    output logic              gen_call_o,
    output logic              rw_o,
    output logic              reserved_o
);

    localparam int BYTE_W = ADDR_W + 1;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_full;
    logic              own_hit, gc_hit, rsvd_hit;
    rcv_state_t        state_q, state_d;
    logic              ack_q, addr_q, gcall_q, rw_q, rsvd_q;
    logic              load;

    i2c_ar_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    i2c_ar_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_c | stop_c),
        .shift_i (scl_rise && state_q == ST_ADDR),
        .bit_i   (sda_s),
        .byte_o  (rx_byte),
        .full_o  (rx_full)
    );

    i2c_ar_classify #(.ADDR_W(ADDR_W)) u_cls (
        .byte_i    (rx_byte),
        .own_i     (own_addr_i),
        .gc_en_i   (gc_en_i),
        .own_hit_o (own_hit),
        .gc_hit_o  (gc_hit),
        .rsvd_o    (rsvd_hit)
    );

    assign load = (state_q == ST_ADDR) && rx_full && !start_c && !stop_c;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_c) begin
            state_d = ST_ADDR;
        end else if (stop_c) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      ;
                ST_ADDR:      if (rx_full) state_d = ST_ACK_WAIT;
                ST_ACK_WAIT:  if (scl_fall) state_d = ack_q ? ST_ACK_DRIVE : ST_IGNORE;
                ST_ACK_DRIVE: if (scl_fall) state_d = ST_ACTIVE;
                ST_ACTIVE:    ;
                ST_IGNORE:    ;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // classification flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            addr_q  <= 1'b0;
            gcall_q <= 1'b0;
            rw_q    <= 1'b0;
            rsvd_q  <= 1'b0;
        end else if (start_c || stop_c) begin
            ack_q   <= 1'b0;
            addr_q  <= 1'b0;
            gcall_q <= 1'b0;
            rw_q    <= 1'b0;
            rsvd_q  <= 1'b0;
        end else if (load) begin
            ack_q   <= own_hit | gc_hit;
            addr_q  <= own_hit;
            gcall_q <= gc_hit;
            rw_q    <= rx_byte[0];
            rsvd_q  <= rsvd_hit;
        end
    end

    // outputs
    always_comb begin
        sda_drive_low_o = (state_q == ST_ACK_DRIVE);
        addressed_o     = addr_q;
        gen_call_o      = gcall_q;
        rw_o            = rw_q;
        reserved_o      = rsvd_q;
    end

    // R4
    drive_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low_o |-> (addressed_o || gen_call_o));

    // R4
    drive_starts_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !scl_s);

    // R5
    own_gcall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addressed_o && gen_call_o));

    // R6
    gcall_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_call_o) |-> $past(gc_en_i));

    // R8
    reserved_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_o |-> (!sda_drive_low_o && !addressed_o && !gen_call_o));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (!addressed_o && !gen_call_o && !reserved_o && !sda_drive_low_o));

    // R11
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (!addressed_o && !gen_call_o && !reserved_o && !sda_drive_low_o));

    // R12
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !start_c && !stop_c) |=>
            ($stable(addressed_o) && $stable(gen_call_o) && !sda_drive_low_o));

endmodule

// File: tb/sim_i2c_addr_recognizer.sv
module sim_i2c_addr_recognizer;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [6:0] own = 7'h2A;
    logic       gc_en = 1'b1;
    logic       drv, addressed, gcall, rw, rsvd;
    logic       sda_bus;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~drv;

    i2c_addr_recognizer #(.ADDR_W(7), .SYNC_STAGES(2)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (m_scl),
        .sda_i           (sda_bus),
        .own_addr_i      (own),
        .gc_en_i         (gc_en),
        .sda_drive_low_o (drv),
        .addressed_o     (addressed),
        .gen_call_o      (gcall),
        .rw_o            (rw),
        .reserved_o      (rsvd)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, "drive", drv, 1'b0);
        chk(tag, "addressed", addressed, 1'b0);
        chk(tag, "gen_call", gcall, 1'b0);
        chk(tag, "reserved", rsvd, 1'b0);
    endtask

    task automatic bus_start;
        m_sda = 1'b0; step(H);
        m_scl = 1'b0; step(H);
    endtask

    task automatic bus_rstart;
        m_sda = 1'b1; step(H);
        m_scl = 1'b1; step(H);
        bus_start();
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; step(H);
        m_scl = 1'b1; step(H);
        m_sda = 1'b1; step(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; step(H);
            m_scl = 1'b1; step(H);
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input string tag, input logic [7:0] b, input logic ack,
                             input logic a, input logic g, input logic r, input logic dir);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; step(H);
            m_scl = 1'b1; step(H);
            if (i == 0) chk("R4", {tag, " no drive in bit 8"}, drv, 1'b0);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; step(H / 2);
        chk(tag, "drive in ack low phase", drv, ack);
        step(H / 2);
        m_scl = 1'b1; step(H / 2);
        chk(tag, "ack on bus", ~sda_bus, ack);
        chk(tag, "addressed", addressed, a);
        chk(tag, "gen_call", gcall, g);
        chk(tag, "reserved", rsvd, r);
        if (a || g) chk("R3", {tag, " rw"}, rw, dir);
        step(H / 2);
        m_scl = 1'b0; step(H / 2);
        chk("R4", {tag, " released after 9th"}, drv, 1'b0);
    endtask

    task automatic t_reset;
        chk_idle("R11");
    endtask

    task automatic t_own_write;
        own = 7'h2A;
        bus_start();
        chk_idle("R1");
        send_byte("R2", 8'h54, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send_byte("R12", 8'h54, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_stop();
        chk_idle("R11");
    endtask

    task automatic t_own_read;
        bus_start();
        send_byte("R3", 8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        bus_stop();
    endtask

    task automatic t_gcall;
        gc_en = 1'b1;
        bus_start();
        send_byte("R5", 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        send_byte("R12", 8'h06, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        bus_stop();
        gc_en = 1'b0;
        bus_start();
        send_byte("R6", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        bus_stop();
        gc_en = 1'b1;
    endtask

    task automatic t_reserved;
        bus_start(); send_byte("R7", 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); bus_stop();
        bus_start(); send_byte("R8", 8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); bus_stop();
        bus_start(); send_byte("R8", 8'h04, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); bus_stop();
        bus_start(); send_byte("R8", 8'h0A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); bus_stop();
        bus_start(); send_byte("R8", 8'hF2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); bus_stop();
        bus_start(); send_byte("R8", 8'hFC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); bus_stop();
        own = 7'h78;
        bus_start(); send_byte("R8", 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); bus_stop();
        own = 7'h2A;
    endtask

    task automatic t_mismatch;
        bus_start();
        send_byte("R9", 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_byte("R9", 8'h54, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        bus_stop();
    endtask

    task automatic t_rstart;
        bus_start();
        send_bits(8'h20, 4);
        bus_rstart();
        send_byte("R10", 8'h54, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_rstart();
        chk_idle("R10");
        send_byte("R10", 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        bus_stop();
    endtask

    task automatic t_stop_mid;
        bus_start();
        send_bits(8'h54, 3);
        bus_stop();
        chk_idle("R11");
        bus_start();
        send_byte("R11", 8'h54, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_stop();
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(5);
        t_reset();
        t_own_write();
        t_own_read();
        t_gcall();
        t_reserved();
        t_mismatch();
        t_rstart();
        t_stop_mid();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule